// File: doc/BRIEF.md
# Conversion Run Sequencer

This block decides when a delta-sigma style converter runs conversions. A conversion can be requested in two ways. One is a START input pin that is filtered for glitches. The other is a pair of START/STOP opcodes that a serial command decoder hands over as a one-cycle strobe. That strobe is raised at the point in the command byte where the opcode takes effect. The pin level and an internal run flag are ORed together to form the run enable. When commands are used for control, the pin is simply held low.

A counter of `CONV_LEN` master-clock cycles stands in for the modulator and filter. The active-low ready line `rdy_n` is forced high whenever a conversion is triggered. It drops when the result is ready.

- In continuous mode (`single_shot` = 0), conversions run back to back while the run enable holds.
- In one-shot mode (`single_shot` = 1), every trigger yields exactly one conversion.
- A stop request never cuts a conversion short.
- A new trigger during a conversion restarts it.
- A trigger that comes too soon after a ready fall marks the next result as unusable.

Top module: `cvt_seq`

## Requirements
- R1: When `start_pin` is sampled high on 4 consecutive clock edges starting at edge k, a conversion is triggered at edge k+3. At that edge `rdy_n` goes (or stays) high and `busy` goes high.
- R2: A high or low level on `start_pin` held for fewer than 4 sampling edges is ignored. It neither triggers, stops nor restarts a conversion.
- R3: A strobe with `cmd_start` = 1 (start opcode) sets the run flag and triggers a conversion at the same edge. A strobe with `cmd_start` = 0 (stop opcode) clears the flag. The run enable is the filtered pin level ORed with the flag.
- R4: With `single_shot` = 0, when a conversion completes while the run enable is high, the next conversion begins at once. `rdy_n` stays low for 4 cycles and falls again every `CONV_LEN` cycles.
- R5: After a stop (pin low or stop opcode), the conversion in progress still completes and `rdy_n` falls at its end. `busy` then drops and no further conversion starts without a new trigger.
- R6: A trigger while a conversion is in progress restarts it. The next `rdy_n` fall comes `CONV_LEN` cycles after the latest trigger.
- R7: With `single_shot` = 1, each trigger produces exactly one conversion. `busy` is low once `rdy_n` falls, even if the run enable is still high.
- R8: `rdy_n` falls exactly `CONV_LEN` (default 64) clock edges after the edge of the trigger that started the conversion.
- R9: If a trigger lands within `REARM_WIN` (default 22) edges after an `rdy_n` fall, `bad_data` is 1 when that conversion's result becomes ready. Edge F+22 after a fall at F still counts; edge F+23 does not. The following result carries `bad_data` = 0, and `bad_data` changes only when `rdy_n` falls.
- R10: After reset, `rdy_n` = 1, `busy` = 0, `bad_data` = 0 and the run flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pin | input | 1 | START pin level, synchronous to `clk` |
| cmd_strobe | input | 1 | One-cycle pulse when a start or stop opcode takes effect |
| cmd_start | input | 1 | Opcode kind with the strobe: 1 = start, 0 = stop |
| single_shot | input | 1 | Mode bit: 0 = continuous, 1 = one conversion per trigger |
| rdy_n | output | 1 | Active-low data ready |
| busy | output | 1 | High while converting, low when halted |
| bad_data | output | 1 | Set when the ready result came from a too-early restart |

## Verification
The hardest situation to reach is the invalid-result window. It needs an `rdy_n` fall followed by a new trigger placed on an exact edge in the 22 cycles after it. The bench builds it in steps:

1. A one-shot conversion produces a known fall edge F.
2. The mode switches to continuous and a start opcode is placed on edge F+22. This yields one flagged result and then a clean one from the continuing run.
3. A stop opcode halts the run, which gives a fresh fall G.
4. A start opcode on edge G+23 shows that the window has closed.

A short low glitch inside a pin-driven conversion is also timed so that, if it were accepted, it would move the next fall by a few cycles. That shift is detectable.

// File: rtl/cvt_seq_pkg.sv
package cvt_seq_pkg;

    typedef enum logic {
        CMD_STOP  = 1'b0,
        CMD_START = 1'b1
    } cmd_kind_e;

    localparam int unsigned DEF_MIN_PULSE = 4;
    localparam int unsigned DEF_CONV_LEN  = 64;
    localparam int unsigned DEF_LOW_LEN   = 4;
    localparam int unsigned DEF_REARM_WIN = 22;

endpackage

// File: rtl/cvt_pin_filter.sv
module cvt_pin_filter #(
    parameter int unsigned MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise
);
    localparam int unsigned SW = (MIN_PULSE > 2) ? $clog2(MIN_PULSE) : 1;
    localparam logic [SW-1:0] STAB_LAST = SW'(MIN_PULSE - 1);

    typedef struct packed {
        logic          filt;
        logic [SW-1:0] stab;
    } flt_t;

    flt_t st_d, st_q;
    logic accept;

    // a change is accepted on the MIN_PULSE-th consecutive differing sample
    always_comb begin
        st_d   = st_q;
        accept = (pin != st_q.filt) && (st_q.stab == STAB_LAST);
        if (pin != st_q.filt) begin
            if (accept) begin
                st_d.filt = pin;
                st_d.stab = '0;
            end else begin
                st_d.stab = st_q.stab + 1'b1;
            end
        end else begin
            st_d.stab = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.filt;
    assign rise  = accept && pin;

endmodule

// File: rtl/cvt_run_ctrl.sv
module cvt_run_ctrl
    import cvt_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_strobe,
    input  logic cmd_start,
    input  logic pin_level,
    input  logic pin_rise,
    output logic run_en,
    output logic trigger
);
    typedef struct packed {
        logic run;
    } rc_t;

    rc_t st_d, st_q;
    logic op_start, op_stop;

    always_comb begin
        op_start = cmd_strobe && (cmd_kind_e'(cmd_start) == CMD_START);
        op_stop  = cmd_strobe && (cmd_kind_e'(cmd_start) == CMD_STOP);
        st_d     = st_q;
        if (op_start) begin
            st_d.run = 1'b1;
        end else if (op_stop) begin
            st_d.run = 1'b0;
        end
        trigger = pin_rise || op_start;
        run_en  = pin_level || st_d.run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cvt_timer.sv
module cvt_timer #(
    parameter int unsigned CONV_LEN  = 64,
    parameter int unsigned LOW_LEN   = 4,
    parameter int unsigned REARM_WIN = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic run_en,
    input  logic single_shot,
    output logic rdy_n,
    output logic busy,
    output logic bad_data
);
    localparam int unsigned CW = (CONV_LEN > 2) ? $clog2(CONV_LEN) : 1;
    localparam int unsigned RW = $clog2(REARM_WIN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(CONV_LEN - 1);
    localparam logic [CW-1:0] LOW_LAST = CW'(LOW_LEN - 1);
    localparam logic [RW-1:0] WIN_END  = RW'(REARM_WIN);

    typedef struct packed {
        logic          rdy_n;
        logic          busy;
        logic          stale;
        logic          bad;
        logic [CW-1:0] cnt;
        logic [RW-1:0] since;
    } tmr_t;

    tmr_t st_d, st_q;
    logic done, in_win;

    always_comb begin
        st_d   = st_q;
        in_win = (st_q.since < WIN_END);
        done   = st_q.busy && (st_q.cnt == CNT_LAST);
        if (in_win) begin
            st_d.since = st_q.since + 1'b1;
        end
        if (trigger) begin
            st_d.busy  = 1'b1;
            st_d.cnt   = '0;
            st_d.rdy_n = 1'b1;
            st_d.stale = in_win;
        end else if (done) begin
            st_d.rdy_n = 1'b0;
            st_d.bad   = st_q.stale;
            st_d.stale = 1'b0;
            st_d.since = '0;
            st_d.cnt   = '0;
            if (single_shot || !run_en) begin
                st_d.busy = 1'b0;
            end
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (!st_q.rdy_n && (st_q.cnt == LOW_LAST)) begin
                st_d.rdy_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.rdy_n <= 1'b1;
            st_q.since <= WIN_END;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy_n    = st_q.rdy_n;
    assign busy     = st_q.busy;
    assign bad_data = st_q.bad;

endmodule

// File: rtl/cvt_seq.sv
module cvt_seq
    import cvt_seq_pkg::*;
#(
    parameter int unsigned MIN_PULSE = DEF_MIN_PULSE,
    parameter int unsigned CONV_LEN  = DEF_CONV_LEN,
    parameter int unsigned LOW_LEN   = DEF_LOW_LEN,
    parameter int unsigned REARM_WIN = DEF_REARM_WIN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_pin,
    input  logic cmd_strobe,
    input  logic cmd_start,
    input  logic single_shot,
    output logic rdy_n,
    output logic busy,
    output logic bad_data
);
    logic pin_level, pin_rise, run_en, trigger;

    cvt_pin_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (start_pin),
        .level (pin_level),
        .rise  (pin_rise)
    );

    cvt_run_ctrl u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_strobe (cmd_strobe),
        .cmd_start  (cmd_start),
        .pin_level  (pin_level),
        .pin_rise   (pin_rise),
        .run_en     (run_en),
        .trigger    (trigger)
    );

    cvt_timer #(
        .CONV_LEN  (CONV_LEN),
        .LOW_LEN   (LOW_LEN),
        .REARM_WIN (REARM_WIN)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .trigger     (trigger),
        .run_en      (run_en),
        .single_shot (single_shot),
        .rdy_n       (rdy_n),
        .busy        (busy),
        .bad_data    (bad_data)
    );

endmodule

// File: rtl/cvt_seq_chk.sv
module cvt_seq_chk #(
    parameter int unsigned MIN_PULSE = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start_pin,
    input logic cmd_strobe,
    input logic cmd_start,
    input logic single_shot,
    input logic rdy_n,
    input logic busy,
    input logic bad_data
);
    logic [3:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (!start_pin) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != 4'hF) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    AST_START_OPCODE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_start) |=> (busy && rdy_n)); // R3

    AST_BUSY_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cmd_strobe && cmd_start) || (hi_cnt_q >= 4'(MIN_PULSE)))); // R2

    AST_READY_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_n) |-> $past(busy)); // R8

    AST_RAISE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> busy); // R8

    AST_ONE_SHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rdy_n) && $past(single_shot)) |-> !busy); // R7

    AST_FLAG_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bad_data) |-> $fell(rdy_n)); // R9

endmodule

bind cvt_seq cvt_seq_chk #(.MIN_PULSE(MIN_PULSE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pin   (start_pin),
    .cmd_strobe  (cmd_strobe),
    .cmd_start   (cmd_start),
    .single_shot (single_shot),
    .rdy_n       (rdy_n),
    .busy        (busy),
    .bad_data    (bad_data)
);

// File: tb/cvt_seq_test.sv
module cvt_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_pin = 1'b0;
    logic cmd_strobe = 1'b0;
    logic cmd_start = 1'b0;
    logic single_shot = 1'b0;
    logic rdy_n, busy, bad_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cvt_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pin   (start_pin),
        .cmd_strobe  (cmd_strobe),
        .cmd_start   (cmd_start),
        .single_shot (single_shot),
        .rdy_n       (rdy_n),
        .busy        (busy),
        .bad_data    (bad_data)
    );

    typedef struct packed {
        logic [31:0] hi_len;
        logic        mode;
        logic [31:0] falls;
    } vec_t;

    // pin pulse length, mode, expected rdy_n falls in 300 cycles
    localparam vec_t VECS [7] = '{
        '{32'd3,   1'b0, 32'd0},   // R2 short pulse ignored
        '{32'd4,   1'b1, 32'd1},   // R7 one shot
        '{32'd4,   1'b0, 32'd1},   // R5 stop lets conversion finish
        '{32'd70,  1'b0, 32'd2},   // R4 continues while enabled
        '{32'd100, 1'b0, 32'd2},   // R5
        '{32'd134, 1'b0, 32'd3},   // R4
        '{32'd200, 1'b1, 32'd1}    // R7 one shot despite long high
    };

    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) tick();
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start_pin = 1'b0;
        cmd_strobe = 1'b0;
        cmd_start = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        cyc = 0;
    endtask

    task automatic opcode(input logic is_start);
        cmd_strobe = 1'b1;
        cmd_start = is_start;
        tick();
        cmd_strobe = 1'b0;
        cmd_start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int t0, p, f, g;
        do_reset();
        // R10 reset state
        chk("R10 rdy_n", rdy_n, 1);
        chk("R10 busy", busy, 0);
        chk("R10 bad_data", bad_data, 0);

        // vector table
        foreach (VECS[i]) begin
            int falls;
            logic prev;
            do_reset();
            single_shot = VECS[i].mode;
            start_pin = 1'b1;
            falls = 0;
            prev = rdy_n;
            for (int c = 0; c < 300; c++) begin
                tick();
                if (c == int'(VECS[i].hi_len) - 1) start_pin = 1'b0;
                if (prev && !rdy_n) falls++;
                prev = rdy_n;
            end
            chk("R2/R4/R5/R7 fall count", falls, VECS[i].falls);
            chk("R5/R7 halted at end", busy, 0);
        end

        // R3 R8 R4 R5 opcode control in continuous mode
        do_reset();
        single_shot = 1'b0;
        opcode(1'b1);
        t0 = cyc;
        chk("R3 busy after start opcode", busy, 1);
        chk("R3 rdy_n high after start opcode", rdy_n, 1);
        wait_to(t0 + 63);
        chk("R8 rdy_n still high", rdy_n, 1);
        tick();
        chk("R8 rdy_n falls at CONV_LEN", rdy_n, 0);
        chk("R4 keeps running", busy, 1);
        wait_to(t0 + 67);
        chk("R4 rdy_n low for 4 cycles", rdy_n, 0);
        tick();
        chk("R4 rdy_n returns high", rdy_n, 1);
        wait_to(t0 + 79);
        opcode(1'b0);
        wait_to(t0 + 127);
        chk("R5 current conversion still running", rdy_n, 1);
        tick();
        chk("R5 final rdy_n fall", rdy_n, 0);
        chk("R5 busy drops", busy, 0);
        wait_to(t0 + 228);
        chk("R5 no further conversion", busy, 0);
        chk("R5 rdy_n stays low", rdy_n, 0);

        // R1 pin rise timing, R2 glitch, R6 restart
        start_pin = 1'b1;
        p = cyc + 1;
        wait_to(p + 2);
        chk("R1 rdy_n low before 4th sample", rdy_n, 0);
        tick();
        chk("R1 rdy_n high on 4th sample", rdy_n, 1);
        chk("R1 busy", busy, 1);
        p = p + 3;
        wait_to(p + 9);
        start_pin = 1'b0;
        wait_to(p + 12);
        start_pin = 1'b1;
        wait_to(p + 19);
        start_pin = 1'b0;
        wait_to(p + 23);
        start_pin = 1'b1;
        wait_to(p + 64);
        chk("R6 no fall at original end", rdy_n, 1);
        wait_to(p + 90);
        chk("R2 glitch ignored, no early fall", rdy_n, 1);
        tick();
        chk("R6 fall CONV_LEN after restart", rdy_n, 0);
        start_pin = 1'b0;
        wait_to(p + 300);
        chk("R5 pin low halts", busy, 0);

        // R9 invalid-result window
        do_reset();
        single_shot = 1'b1;
        opcode(1'b1);
        t0 = cyc;
        wait_to(t0 + 64);
        f = cyc;
        chk("R7 one shot fall", rdy_n, 0);
        chk("R7 one shot halted", busy, 0);
        chk("R9 first result clean", bad_data, 0);
        single_shot = 1'b0;
        wait_to(f + 21);
        opcode(1'b1);
        wait_to(f + 86);
        chk("R9 early restart fall", rdy_n, 0);
        chk("R9 early restart flagged", bad_data, 1);
        wait_to(f + 150);
        chk("R9 next fall", rdy_n, 0);
        chk("R9 next result clean", bad_data, 0);
        wait_to(f + 159);
        opcode(1'b0);
        wait_to(f + 214);
        g = cyc;
        chk("R5 halted after stop", busy, 0);
        single_shot = 1'b1;
        wait_to(g + 22);
        opcode(1'b1);
        wait_to(g + 86);
        chk("R9 window boundary flag unchanged", bad_data, 0);
        tick();
        chk("R9 fall after boundary start", rdy_n, 0);
        chk("R9 boundary start not flagged", bad_data, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule